// File: doc/BRIEF.md
# Link Fault Response Controller

This block sits between a transmit MAC and a 64-bit, eight-lane parallel Ethernet interface in which each lane carries one byte and one control flag. It inspects every received column for sequence ordered sets that report a local fault or a remote fault. It keeps a registered fault status, and it decides each cycle whether the client's transmit column goes out unchanged or is replaced by a remote-fault ordered set or an idle column.

A two-bit policy input selects among three behaviours. With the policy off, the client stream is never altered. The unidirectional policy keeps frames flowing during a local fault, places remote-fault ordered sets only into the gaps between packets, and ignores incoming remote faults. The bidirectional policy replaces all traffic while a fault lasts: a local fault yields a continuous stream of remote-fault sets and a remote fault yields continuous idles. Every replacement starts and ends only at a frame boundary, so no frame is ever cut in two.

Top module: `link_fault_ctl`

## Requirements
- R1: While reset is held, and until the first column is processed after it, the transmit output is an idle column (every control flag set, every byte 0x07) and both fault status outputs are low.
- R2: A received column is a fault ordered set when its control mask is 0x01, lane 0 (bits 7:0) is 0x9C, lanes 1 and 2 are 0x00, and lane 3 (bits 31:24) holds 0x01 for a local fault or 0x02 for a remote fault. The matching status output goes high one cycle after the fourth set of one type in a row. A set of the other type restarts the count at one.
- R3: Two sets count as consecutive only when fewer than 128 non-set columns separate them. A set that follows 128 or more non-set columns starts a new count at one.
- R4: A fault status clears one cycle after the 128th consecutive column that holds no fault ordered set.
- R5: With policy 0 (off), the transmit output equals the client column of the previous cycle, whatever the fault status.
- R6: With policy 1 (unidirectional) and a local fault, every client column that is outside a frame and is not a start column is sent as a remote-fault ordered set. Frames pass unchanged from their start column (control flag on lane 0, byte 0xFB) through their terminate column (any lane with its control flag set and byte 0xFD).
- R7: With policy 1 and only a remote fault, the client stream passes unchanged.
- R8: With policy 2 (bidirectional), a local fault replaces every transmitted column with a remote-fault ordered set, and a remote fault replaces every column with an idle column. Client frames that start during the fault are dropped whole.
- R9: A frame already in progress when a replacement begins is sent through its terminate column. When the fault clears in the middle of a dropped frame, replacement continues through that frame's terminate column, and the client stream resumes at the next column.
- R10: The local fault and remote fault status outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the receive monitor and the transmit path |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Fault policy: 0 off, 1 unidirectional, 2 bidirectional, 3 treated as off |
| rx_data | input | 64 | Received column data, lane n in bits 8n+7:8n |
| rx_ctrl | input | 8 | Received column control flags, one per lane |
| cli_data | input | 64 | Client transmit column data from the MAC |
| cli_ctrl | input | 8 | Client transmit column control flags |
| tx_data | output | 64 | Transmitted column data, registered |
| tx_ctrl | output | 8 | Transmitted column control flags, registered |
| local_fault | output | 1 | Registered local fault status |
| remote_fault | output | 1 | Registered remote fault status |

## Verification
The assertions check on every cycle that the two status outputs never overlap, that a status rises only right after a matching ordered set and falls only after a column with no set, and that outside a frame the off and unidirectional policies send either the client column or a remote-fault set, as their rules allow. Only the bench's scenarios can show the count thresholds: the fourth set against the third, a window of 127 columns against one of 128, and the clearing column. They also show the frame-boundary timing of bidirectional replacement, both at its start and when it ends in the middle of a dropped frame.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    localparam int LANES = 8;
    localparam int COL_W = LANES * 8;

    localparam logic [7:0] CH_SEQ   = 8'h9C;
    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CODE_LF  = 8'h01;
    localparam logic [7:0] CODE_RF  = 8'h02;

    typedef enum logic [1:0] {
        POL_OFF   = 2'b00,
        POL_UNI   = 2'b01,
        POL_BIDIR = 2'b10,
        POL_RSVD  = 2'b11
    } fault_policy_e;

    typedef enum logic [1:0] {
        FK_NONE   = 2'b00,
        FK_LOCAL  = 2'b01,
        FK_REMOTE = 2'b10
    } fault_kind_e;

    typedef enum logic [1:0] {
        ACT_PASS,
        ACT_FILL,
        ACT_GAP_RF
    } tx_action_e;

    typedef struct packed {
        logic [COL_W-1:0] data;
        logic [LANES-1:0] ctrl;
    } xg_col_t;

    function automatic logic [7:0] lane_byte(xg_col_t c, int idx);
        return c.data[idx*8 +: 8];
    endfunction

    function automatic fault_kind_e seq_kind(xg_col_t c);
        fault_kind_e k;
        k = FK_NONE;
        if (c.ctrl == LANES'(1) && lane_byte(c, 0) == CH_SEQ &&
            lane_byte(c, 1) == 8'h00 && lane_byte(c, 2) == 8'h00) begin
            if (lane_byte(c, 3) == CODE_LF)
                k = FK_LOCAL;
            else if (lane_byte(c, 3) == CODE_RF)
                k = FK_REMOTE;
        end
        return k;
    endfunction

    function automatic logic is_start(xg_col_t c);
        return c.ctrl[0] && (lane_byte(c, 0) == CH_START);
    endfunction

    function automatic logic has_term(xg_col_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (c.ctrl[i] && lane_byte(c, i) == CH_TERM)
                hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic xg_col_t idle_col();
        xg_col_t c;
        c.data = {LANES{CH_IDLE}};
        c.ctrl = '1;
        return c;
    endfunction

    function automatic xg_col_t rf_col();
        xg_col_t c;
        c.data        = '0;
        c.data[7:0]   = CH_SEQ;
        c.data[31:24] = CODE_RF;
        c.ctrl        = LANES'(1);
        return c;
    endfunction

endpackage

// File: rtl/lfc_rx_monitor.sv
module lfc_rx_monitor
    import lfc_pkg::*;
#(
    parameter int DECLARE_CNT = 4,
    parameter int CLEAR_COLS  = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  xg_col_t rx_col,
    output logic    local_fault,
    output logic    remote_fault
);

    localparam int SEQ_W = $clog2(DECLARE_CNT + 1);
    localparam int GAP_W = $clog2(CLEAR_COLS + 1);
    localparam logic [SEQ_W-1:0] SEQ_MAX = SEQ_W'(DECLARE_CNT);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CLEAR_COLS);

    fault_kind_e      kind;
    fault_kind_e      last_q;
    fault_kind_e      stat_q;
    logic [SEQ_W-1:0] seq_q;
    logic [GAP_W-1:0] gap_q;

    assign kind = seq_kind(rx_col);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= FK_NONE;
            stat_q <= FK_NONE;
            seq_q  <= '0;
            gap_q  <= GAP_MAX;
        end else if (kind != FK_NONE) begin
            gap_q <= '0;
            if (kind == last_q && gap_q < GAP_MAX) begin
                if (seq_q < SEQ_MAX)
                    seq_q <= seq_q + 1'b1;
                if (seq_q >= SEQ_MAX - 1'b1)
                    stat_q <= kind;
            end else begin
                last_q <= kind;
                seq_q  <= SEQ_W'(1);
            end
        end else begin
            if (gap_q < GAP_MAX)
                gap_q <= gap_q + 1'b1;
            if (gap_q == GAP_MAX - 1'b1) begin
                stat_q <= FK_NONE;
                seq_q  <= '0;
            end
        end
    end

    assign local_fault  = (stat_q == FK_LOCAL);
    assign remote_fault = (stat_q == FK_REMOTE);

endmodule

// File: rtl/lfc_frame_track.sv
module lfc_frame_track
    import lfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  xg_col_t cli_col,
    output logic    in_frame
);

    always_ff @(posedge clk) begin
        if (rst)
            in_frame <= 1'b0;
        else if (has_term(cli_col))
            in_frame <= 1'b0;
        else if (is_start(cli_col))
            in_frame <= 1'b1;
    end

endmodule

// File: rtl/lfc_tx_mux.sv
module lfc_tx_mux
    import lfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  fault_policy_e policy,
    input  logic          local_fault,
    input  logic          remote_fault,
    input  logic          in_frame,
    input  xg_col_t       cli_col,
    output xg_col_t       tx_col
);

    logic       want_blk;
    logic       blk_q;
    logic       blk_n;
    logic       gap_slot;
    tx_action_e act;
    xg_col_t    fill;
    xg_col_t    nxt;

    always_comb begin
        want_blk = (policy == POL_BIDIR) && (local_fault || remote_fault);
        // Replacement may only switch on or off between frames.
        blk_n    = in_frame ? blk_q : want_blk;
        gap_slot = (policy == POL_UNI) && local_fault && !in_frame && !is_start(cli_col);
        fill     = local_fault ? rf_col() : idle_col();

        if (blk_n)
            act = ACT_FILL;
        else if (gap_slot)
            act = ACT_GAP_RF;
        else
            act = ACT_PASS;

        case (act)
            ACT_FILL:   nxt = fill;
            ACT_GAP_RF: nxt = rf_col();
            default:    nxt = cli_col;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= 1'b0;
            tx_col <= idle_col();
        end else begin
            blk_q  <= blk_n;
            tx_col <= nxt;
        end
    end

endmodule

// File: rtl/link_fault_ctl.sv
module link_fault_ctl
    import lfc_pkg::*;
#(
    parameter int DECLARE_CNT = 4,
    parameter int CLEAR_COLS  = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [COL_W-1:0] rx_data,
    input  logic [LANES-1:0] rx_ctrl,
    input  logic [COL_W-1:0] cli_data,
    input  logic [LANES-1:0] cli_ctrl,
    output logic [COL_W-1:0] tx_data,
    output logic [LANES-1:0] tx_ctrl,
    output logic             local_fault,
    output logic             remote_fault
);

    xg_col_t       rx_col;
    xg_col_t       cli_col;
    xg_col_t       tx_col;
    fault_policy_e policy;
    logic          cli_in_frame;

    assign rx_col  = '{data: rx_data, ctrl: rx_ctrl};
    assign cli_col = '{data: cli_data, ctrl: cli_ctrl};
    assign policy  = fault_policy_e'(mode);

    lfc_rx_monitor #(
        .DECLARE_CNT (DECLARE_CNT),
        .CLEAR_COLS  (CLEAR_COLS)
    ) u_mon (
        .clk          (clk),
        .rst          (rst),
        .rx_col       (rx_col),
        .local_fault  (local_fault),
        .remote_fault (remote_fault)
    );

    lfc_frame_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .cli_col  (cli_col),
        .in_frame (cli_in_frame)
    );

    lfc_tx_mux u_mux (
        .clk          (clk),
        .rst          (rst),
        .policy       (policy),
        .local_fault  (local_fault),
        .remote_fault (remote_fault),
        .in_frame     (cli_in_frame),
        .cli_col      (cli_col),
        .tx_col       (tx_col)
    );

    assign tx_data = tx_col.data;
    assign tx_ctrl = tx_col.ctrl;

endmodule

// File: rtl/lfc_checker.sv
module lfc_checker
    import lfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic [COL_W-1:0] rx_data,
    input logic [LANES-1:0] rx_ctrl,
    input logic [COL_W-1:0] cli_data,
    input logic [LANES-1:0] cli_ctrl,
    input logic [COL_W-1:0] tx_data,
    input logic [LANES-1:0] tx_ctrl,
    input logic             local_fault,
    input logic             remote_fault,
    input logic             cli_in_frame
);

    xg_col_t rx_c;
    xg_col_t cli_c;
    xg_col_t tx_c;
    xg_col_t rf_c;

    assign rx_c  = '{data: rx_data, ctrl: rx_ctrl};
    assign cli_c = '{data: cli_data, ctrl: cli_ctrl};
    assign tx_c  = '{data: tx_data, ctrl: tx_ctrl};
    assign rf_c  = rf_col();

    // R10
    status_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(local_fault && remote_fault));

    // R2
    lf_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(local_fault) |-> ($past(seq_kind(rx_c)) == FK_LOCAL));

    // R2
    rf_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(remote_fault) |-> ($past(seq_kind(rx_c)) == FK_REMOTE));

    // R4
    lf_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(local_fault) && !remote_fault) |-> ($past(seq_kind(rx_c)) == FK_NONE));

    // R5
    off_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_OFF && !cli_in_frame) |=> (tx_c == $past(cli_c)));

    // R7
    uni_no_lf_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_UNI && !local_fault && !cli_in_frame) |=> (tx_c == $past(cli_c)));

    // R6
    uni_output_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == POL_UNI && !cli_in_frame) |=> (tx_c == $past(cli_c) || tx_c == rf_c));

endmodule

bind link_fault_ctl lfc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .rx_data      (rx_data),
    .rx_ctrl      (rx_ctrl),
    .cli_data     (cli_data),
    .cli_ctrl     (cli_ctrl),
    .tx_data      (tx_data),
    .tx_ctrl      (tx_ctrl),
    .local_fault  (local_fault),
    .remote_fault (remote_fault),
    .cli_in_frame (cli_in_frame)
);

// File: tb/link_fault_ctl_bench.sv
module link_fault_ctl_bench;

    localparam logic [71:0] C_IDLE  = {64'h0707070707070707, 8'hFF};
    localparam logic [71:0] C_LF    = {64'h000000000100009C, 8'h01};
    localparam logic [71:0] C_RF    = {64'h000000000200009C, 8'h01};
    localparam logic [71:0] C_START = {64'hD5555555555555FB, 8'h01};
    localparam logic [71:0] C_DATA  = {64'h1122334455667788, 8'h00};
    localparam logic [71:0] C_DATA2 = {64'hA5A5C3C30F0FF00F, 8'h00};
    localparam logic [71:0] C_TERM  = {64'h07070707070707FD, 8'hFF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [63:0] rx_data;
    logic [7:0]  rx_ctrl;
    logic [63:0] cli_data;
    logic [7:0]  cli_ctrl;
    logic [63:0] tx_data;
    logic [7:0]  tx_ctrl;
    logic        local_fault;
    logic        remote_fault;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    link_fault_ctl u_link_fault_ctl (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .rx_data      (rx_data),
        .rx_ctrl      (rx_ctrl),
        .cli_data     (cli_data),
        .cli_ctrl     (cli_ctrl),
        .tx_data      (tx_data),
        .tx_ctrl      (tx_ctrl),
        .local_fault  (local_fault),
        .remote_fault (remote_fault)
    );

    // Drive one receive and one client column, then wait until the
    // outputs reflect that column.
    task automatic col(input logic [71:0] rx, input logic [71:0] cl);
        {rx_data, rx_ctrl}   = rx;
        {cli_data, cli_ctrl} = cl;
        @(negedge clk);
    endtask

    task automatic cols(input int n, input logic [71:0] rx, input logic [71:0] cl);
        for (int i = 0; i < n; i++) col(rx, cl);
    endtask

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] txo();
        return {tx_data, tx_ctrl};
    endfunction

    function automatic logic [71:0] st();
        return {70'd0, local_fault, remote_fault};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        cols(3, C_IDLE, C_DATA);
        chk("R1 tx idle in reset", txo(), C_IDLE);
        chk("R1 status low in reset", st(), 72'd0);
        rst = 1'b0;
    endtask

    task automatic t_declare();
        mode = 2'b00;
        cols(3, C_LF, C_IDLE);
        chk("R2 no fault after 3 sets", st(), 72'd0);
        col(C_LF, C_IDLE);
        chk("R2 local fault after 4th set", st(), 72'd2);
        col(C_IDLE, C_DATA);
        chk("R5 off mode passes client", txo(), C_DATA);
        col(C_LF, C_DATA2);
        chk("R5 off mode ignores fault", txo(), C_DATA2);
    endtask

    task automatic t_clear();
        cols(127, C_IDLE, C_IDLE);
        chk("R4 still set after 127 columns", st(), 72'd2);
        col(C_IDLE, C_IDLE);
        chk("R4 cleared after 128 columns", st(), 72'd0);
    endtask

    task automatic t_window();
        cols(3, C_LF, C_IDLE);
        cols(127, C_IDLE, C_IDLE);
        col(C_LF, C_IDLE);
        chk("R3 127-column gap keeps count", st(), 72'd2);
        cols(128, C_IDLE, C_IDLE);
        cols(3, C_LF, C_IDLE);
        cols(128, C_IDLE, C_IDLE);
        cols(3, C_LF, C_IDLE);
        chk("R3 128-column gap restarts count", st(), 72'd0);
        col(C_LF, C_IDLE);
        chk("R3 fourth set after restart", st(), 72'd2);
        cols(128, C_IDLE, C_IDLE);
    endtask

    task automatic t_mixed();
        cols(3, C_LF, C_IDLE);
        col(C_RF, C_IDLE);
        chk("R2 mixed types no fault", st(), 72'd0);
        cols(3, C_RF, C_IDLE);
        chk("R2 R10 remote fault only", st(), 72'd1);
        cols(128, C_IDLE, C_IDLE);
        chk("R4 remote cleared", st(), 72'd0);
    endtask

    task automatic t_uni_lf();
        mode = 2'b01;
        cols(4, C_LF, C_IDLE);
        chk("R6 local fault set", st(), 72'd2);
        col(C_LF, C_IDLE);
        chk("R6 gap gets remote-fault set", txo(), C_RF);
        col(C_LF, C_START);
        chk("R6 start passes", txo(), C_START);
        col(C_LF, C_DATA);
        chk("R6 data passes", txo(), C_DATA);
        col(C_LF, C_TERM);
        chk("R6 terminate passes", txo(), C_TERM);
        col(C_LF, C_IDLE);
        chk("R6 gap after frame", txo(), C_RF);
        cols(128, C_IDLE, C_IDLE);
        col(C_IDLE, C_IDLE);
        chk("R6 gap fill stops after clear", txo(), C_IDLE);
    endtask

    task automatic t_uni_rf();
        mode = 2'b01;
        cols(4, C_RF, C_IDLE);
        chk("R7 remote fault set", st(), 72'd1);
        col(C_RF, C_IDLE);
        chk("R7 remote fault ignored in gap", txo(), C_IDLE);
        col(C_RF, C_START);
        chk("R7 start passes", txo(), C_START);
        col(C_RF, C_TERM);
        chk("R7 terminate passes", txo(), C_TERM);
        cols(128, C_IDLE, C_IDLE);
    endtask

    task automatic t_bidir();
        mode = 2'b10;
        col(C_IDLE, C_START);
        cols(4, C_LF, C_DATA);
        chk("R8 local fault set", st(), 72'd2);
        col(C_LF, C_DATA2);
        chk("R9 frame in progress continues", txo(), C_DATA2);
        col(C_LF, C_TERM);
        chk("R9 terminate sent", txo(), C_TERM);
        col(C_LF, C_IDLE);
        chk("R8 remote-fault fill", txo(), C_RF);
        col(C_LF, C_START);
        chk("R8 new frame start dropped", txo(), C_RF);
        col(C_LF, C_DATA);
        chk("R8 new frame data dropped", txo(), C_RF);
        col(C_LF, C_TERM);
        chk("R8 new frame end dropped", txo(), C_RF);
        cols(4, C_RF, C_IDLE);
        chk("R10 switched to remote fault", st(), 72'd1);
        col(C_RF, C_IDLE);
        chk("R8 idle fill on remote fault", txo(), C_IDLE);
        col(C_RF, C_START);
        chk("R8 start dropped on remote fault", txo(), C_IDLE);
        cols(128, C_IDLE, C_DATA);
        chk("R4 remote cleared mid-frame", st(), 72'd0);
        col(C_IDLE, C_DATA2);
        chk("R9 dropped frame stays dropped", txo(), C_IDLE);
        col(C_IDLE, C_TERM);
        chk("R9 dropped frame end replaced", txo(), C_IDLE);
        col(C_IDLE, C_START);
        chk("R9 resumes at next frame", txo(), C_START);
        col(C_IDLE, C_TERM);
        chk("R9 resumed frame end", txo(), C_TERM);
    endtask

    initial begin
        {rx_data, rx_ctrl}   = C_IDLE;
        {cli_data, cli_ctrl} = C_IDLE;
        @(negedge clk);
        t_reset();
        t_declare();
        t_clear();
        t_window();
        t_mixed();
        t_uni_lf();
        t_uni_rf();
        t_bidir();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule